// File: doc/BRIEF.md
# Base-16 Floating-Point Multiplier

This block multiplies two 32-bit floating-point words that use a hexadecimal scale factor. Bit 31 holds the sign. Bits 30:24 hold a 7-bit exponent stored with an offset of 64, so the stored codes 0 to 127 stand for the powers 16^-64 to 16^63. Bits 23:0 hold a 24-bit unsigned fraction whose binary point sits to the left of bit 23. An operand is normalized when its top hex digit (bits 23:20) is nonzero.

An operand is presented on `a_i` and `b_i` together with `valid_i`. The block then forms the full 48-bit fraction product and adds the stored exponents, less the offset. If the leading hex digit of the product is zero, the product is shifted left by one digit. The fraction is then cut to 24 bits by dropping the low bits. The result comes out two clocks later with `valid_o`. Flags report a result that is too large or too small for the exponent range. A new operation can be accepted on every clock.

Top module: `hfp_mul`

## Requirements
- R1: The sign bit (bit 31) of a nonzero result is the XOR of the two operand sign bits.
- R2: When the leading hex digit (bits 47:44) of the 48-bit fraction product is nonzero, the result exponent code is EA + EB - 64, and the result fraction is product bits 47:24.
- R3: When that leading hex digit is zero, the product is shifted left by 4 bits before the fraction is taken, and the exponent code becomes EA + EB - 65.
- R4: Fraction bits below the kept 24 are discarded without rounding.
- R5: An operand whose fraction field (bits 23:0) is zero counts as zero. The result is then the all-zero word, and neither flag is set.
- R6: If the final exponent code is above 127, `ovf_o` is set, and the result saturates to the correct sign, exponent 127 and fraction 0xFFFFFF.
- R7: If the final exponent code is below 0, `unf_o` is set and the result is the all-zero word.
- R8: `valid_o` is high exactly two clocks after each cycle in which `valid_i` is high. Back-to-back inputs produce back-to-back results.
- R9: While `rst_ni` is low, `valid_o`, `p_o`, `ovf_o` and `unf_o` are all zero.
- R10: `ovf_o` and `unf_o` are never both high. Both stay low whenever `valid_o` is low.

Operands are assumed to be normalized or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands present this cycle |
| a_i | input | 32 | First operand word |
| b_i | input | 32 | Second operand word |
| valid_o | output | 1 | Result present this cycle |
| p_o | output | 32 | Product word |
| ovf_o | output | 1 | Exponent above the representable range |
| unf_o | output | 1 | Exponent below the representable range |

## Verification
The hardest case to reach is an exponent sum on the edge of the range, where the one-digit normalization shift is the only thing that decides whether the result underflows or overflows. Random normalized operands rarely land exactly there. Directed pairs are therefore mixed in:
- pairs with a sum of 0 and small fractions, whose shift pushes the exponent to -1;
- pairs with a sum of 0 and large fractions, which stay at 0;
- pairs that reach exactly 127 and 128.

Random traffic with gaps in `valid_i` covers the pipeline timing.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  localparam int EXP_W  = 7;
  localparam int MAN_W  = 24;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int DIG_W  = 4;
  localparam int PROD_W = 2 * MAN_W;
  localparam int SEXP_W = EXP_W + 3;
  localparam int BIAS   = 1 << (EXP_W - 1);
  localparam int EMAX   = (1 << EXP_W) - 1;
endpackage

// File: rtl/hfp_mul_mult.sv
module hfp_mul_mult
  import hfp_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [WORD_W-1:0]        a_i,
  input  logic [WORD_W-1:0]        b_i,
  output logic                     valid_q_o,
  output logic                     zero_q_o,
  output logic                     sign_q_o,
  output logic signed [SEXP_W-1:0] exp_q_o,
  output logic [PROD_W-1:0]        prod_q_o
);
  logic [MAN_W-1:0] man_a, man_b;
  logic [EXP_W-1:0] ex_a, ex_b;
  logic signed [SEXP_W-1:0] exp_sum;

  assign man_a = a_i[MAN_W-1:0];
  assign man_b = b_i[MAN_W-1:0];
  assign ex_a  = a_i[WORD_W-2 -: EXP_W];
  assign ex_b  = b_i[WORD_W-2 -: EXP_W];
  assign exp_sum = $signed({3'b000, ex_a}) + $signed({3'b000, ex_b})
                 - $signed(SEXP_W'(BIAS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q_o <= 1'b0;
      zero_q_o  <= 1'b0;
      sign_q_o  <= 1'b0;
      exp_q_o   <= '0;
      prod_q_o  <= '0;
    end else begin
      valid_q_o <= valid_i;
      if (valid_i) begin
        zero_q_o <= (man_a == '0) || (man_b == '0);
        sign_q_o <= a_i[WORD_W-1] ^ b_i[WORD_W-1];
        exp_q_o  <= exp_sum;
        prod_q_o <= man_a * man_b;
      end
    end
  end
endmodule

// File: rtl/hfp_mul_norm.sv
module hfp_mul_norm
  import hfp_pkg::*;
(
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     zero_i,
  input  logic                     sign_i,
  input  logic signed [SEXP_W-1:0] exp_i,
  input  logic [PROD_W-1:0]        prod_i,
  output logic                     valid_o,
  output logic [WORD_W-1:0]        word_o,
  output logic                     ovf_o,
  output logic                     unf_o
);
  localparam logic signed [SEXP_W-1:0] EHI = SEXP_W'(EMAX);

  logic                     lead_zero;
  logic [MAN_W-1:0]         man_n;
  logic signed [SEXP_W-1:0] exp_n;
  logic                     ovf_n, unf_n;
  logic [WORD_W-1:0]        word_n;

  always_comb begin
    lead_zero = (prod_i[PROD_W-1 -: DIG_W] == '0);
    // one hex digit shift is enough for normalized operands
    man_n = lead_zero ? prod_i[PROD_W-1-DIG_W -: MAN_W] : prod_i[PROD_W-1 -: MAN_W];
    exp_n = exp_i - (lead_zero ? SEXP_W'(1) : SEXP_W'(0));
    ovf_n = !zero_i && (exp_n > EHI);
    unf_n = !zero_i && (exp_n < 0);
    if (zero_i || unf_n)
      word_n = '0;
    else if (ovf_n)
      word_n = {sign_i, {EXP_W{1'b1}}, {MAN_W{1'b1}}};
    else
      word_n = {sign_i, exp_n[EXP_W-1:0], man_n};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      word_o  <= '0;
      ovf_o   <= 1'b0;
      unf_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      ovf_o   <= valid_i && ovf_n;
      unf_o   <= valid_i && unf_n;
      if (valid_i) word_o <= word_n;
    end
  end
endmodule

// File: rtl/hfp_mul.sv
module hfp_mul
  import hfp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] p_o,
  output logic              ovf_o,
  output logic              unf_o
);
  logic                     s1_valid, s1_zero, s1_sign;
  logic signed [SEXP_W-1:0] s1_exp;
  logic [PROD_W-1:0]        s1_prod;

  hfp_mul_mult u_mult (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .a_i       (a_i),
    .b_i       (b_i),
    .valid_q_o (s1_valid),
    .zero_q_o  (s1_zero),
    .sign_q_o  (s1_sign),
    .exp_q_o   (s1_exp),
    .prod_q_o  (s1_prod)
  );

  hfp_mul_norm u_norm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (s1_valid),
    .zero_i  (s1_zero),
    .sign_i  (s1_sign),
    .exp_i   (s1_exp),
    .prod_i  (s1_prod),
    .valid_o (valid_o),
    .word_o  (p_o),
    .ovf_o   (ovf_o),
    .unf_o   (unf_o)
  );
endmodule

// File: rtl/hfp_mul_chk.sv
module hfp_mul_chk
  import hfp_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [WORD_W-1:0] a_i,
  input logic [WORD_W-1:0] b_i,
  input logic              valid_o,
  input logic [WORD_W-1:0] p_o,
  input logic              ovf_o,
  input logic              unf_o
);
  p_latency_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o == $past(valid_i, 2));

  p_flag_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ovf_o, unf_o}) && ((ovf_o || unf_o) -> valid_o));

  p_unf_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> (p_o == '0));

  p_ovf_sat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (p_o[WORD_W-2:0] == '1));

  p_norm_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && p_o != '0) |-> (p_o[MAN_W-1 -: DIG_W] != '0));

  p_sign_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && p_o != '0) |->
      (p_o[WORD_W-1] == $past(a_i[WORD_W-1] ^ b_i[WORD_W-1], 2)));

  p_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(a_i[MAN_W-1:0] == '0 || b_i[MAN_W-1:0] == '0, 2))
      |-> (p_o == '0 && !ovf_o && !unf_o));
endmodule

bind hfp_mul hfp_mul_chk u_chk (.*);

// File: tb/hfp_mul_test.sv
module hfp_mul_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic        valid_o, ovf_o, unf_o;
  logic [31:0] p_o;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  logic [33:0] exp_hist [0:4095];
  logic        vin_hist [0:4095];
  string       tag_hist [0:4095];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hfp_mul uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .a_i(a_i), .b_i(b_i),
    .valid_o(valid_o), .p_o(p_o), .ovf_o(ovf_o), .unf_o(unf_o));

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // returns {ovf, unf, word}; tag names the rule that decides the result
  function automatic logic [33:0] model(logic [31:0] a, logic [31:0] b, output string tag);
    logic [47:0] p;
    int e;
    logic s;
    s = a[31] ^ b[31];
    if (a[23:0] == 0 || b[23:0] == 0) begin tag = "R5"; return '0; end
    p = a[23:0] * b[23:0];
    e = int'(a[30:24]) + int'(b[30:24]) - 64;
    tag = "R2";
    if (p[47:44] == 0) begin p = p << 4; e = e - 1; tag = "R3"; end
    if (e > 127) begin tag = "R6"; return {2'b10, s, 7'h7F, 24'hFFFFFF}; end
    if (e < 0) begin tag = "R7"; return {2'b01, 32'h0}; end
    return {2'b00, s, 7'(e), p[47:24]};
  endfunction

  function automatic logic [31:0] rnd_op();
    logic [23:0] m;
    m = 24'($urandom);
    if (m[23:20] == 0) m[23:20] = 4'(1 + $urandom % 15);
    return {1'($urandom), 7'($urandom), m};
  endfunction

  task automatic drive(bit v, logic [31:0] a, logic [31:0] b, string forced_tag = "");
    string t;
    @(negedge clk);
    valid_i = v; a_i = a; b_i = b;
    vin_hist[cyc % 4096] = v;
    exp_hist[cyc % 4096] = model(a, b, t);
    tag_hist[cyc % 4096] = (forced_tag != "") ? forced_tag : t;
  endtask

  // monitor: result for inputs driven at cycle n is seen at negedge of cycle n+2
  initial begin
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      if (done) break;
      if (cyc >= 2 && vin_hist[(cyc-2) % 4096] !== 1'bx) begin
        automatic int k = (cyc - 2) % 4096;
        check("R8", 64'(valid_o), 64'(vin_hist[k]));
        if (valid_o && vin_hist[k]) begin
          check(tag_hist[k], {30'b0, ovf_o, unf_o, p_o}, 64'(exp_hist[k]));
          if (exp_hist[k][31:0] != 0)
            check("R1", 64'(p_o[31]), 64'(exp_hist[k][31]));
        end
        if (!valid_o) check("R10", {62'b0, ovf_o, unf_o}, 64'b0);
      end
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    foreach (vin_hist[i]) vin_hist[i] = 1'bx;
    repeat (3) @(negedge clk);
    check("R9", {30'b0, valid_o, ovf_o, unf_o, p_o[28:0]}, 64'b0);
    check("R9", 64'(p_o), 64'b0);
    rst_n = 1'b1;
    drive(1, 32'h41FFFFFF, 32'h41FFFFFF, "R4");     // 0xFFFFFE, exp 66
    drive(1, 32'hC1800001, 32'h41800001, "R4");
    drive(1, 32'h7F100000, 32'h7F100000);           // overflow
    drive(1, 32'h7F800000, 32'h41800000);           // 128 overflow
    drive(1, 32'h7F800000, 32'h40800000);           // exactly 127
    drive(1, 32'h20100000, 32'hA0100000);           // shift to -1: underflow
    drive(1, 32'h20800000, 32'h20800000);           // stays at 0
    drive(1, 32'h00000000, 32'h7F800000);           // zero operand
    drive(1, 32'hC5000000, 32'h00000000);           // zero fraction, nonzero exp
    drive(0, 32'h0, 32'h0);
    drive(1, 32'h41100000, 32'hC1100000);           // shift case
    for (int i = 0; i < 2000; i++) begin
      bit v;
      logic [31:0] a, b;
      v = ($urandom % 4) != 0;
      a = rnd_op();
      b = rnd_op();
      if ($urandom % 32 == 0) a[23:0] = 0;
      drive(v, a, b);
    end
    drive(0, 0, 0);
    repeat (3) drive(0, 0, 0);
    done = 1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", {31'b0, valid_o, p_o}, 64'b0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++; tests++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule